// File: doc/BRIEF.md
# Splittable Output-Compare Timer

This block is a compare timer. It runs either as one 16-bit up-counter or as two separate 8-bit up-counters, called the low half and the high half. Each counter advances on a tick. Software picks the tick source: one of four taps of a free-running divider on the system clock (divide by 2, 4, 16 or 32), an external event input, or no source, which leaves the counter stopped. A counter that reaches its compare value raises a match flag. It can also clear itself to zero and invert the toggle pin. A counter that wraps past its all-ones value raises an overflow flag. Flags stay set until software clears them. Each flag has its own enable, and the enabled flags together drive one interrupt line.

Software uses a plain register bus. A write takes effect on the clock edge while `bus_we` is high. A read is combinational from `bus_addr` onto `bus_rdata`. The bus has no streaming data path, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

Top module: `split_cmp_timer`

Register map. Addresses are 4 bits, data is 8 bits, and fields not listed read as 0.

- 0: low half configuration. Bits [2:0] select the source: 0 = /2, 1 = /4, 2 = /16, 3 = /32, 4 = external, 5 to 7 = stopped. Bit [3] enables clear on match. Reset value is 0x07.
- 1: high half configuration, with the same layout as address 0.
- 2: mode. Bit [0] set to 1 selects two 8-bit timers. Reset value is 0, which selects 16-bit mode.
- 3: interrupt enables, with the same bit layout as the flags register.
- 4: flags. Bit 0 is low overflow, bit 1 is low match, bit 2 is high overflow, bit 3 is high match.
- 5: pin level. Reading returns the pin. Writing sets the pin to bit 0.
- 6 and 7: low and high counter values. Both are writable.
- 8 and 9: low and high compare values. Both reset to 0xFF.

## Requirements
- R1: A counter advances by one once every N system clocks, where N is 2, 4, 16 or 32 for source codes 0, 1, 2 and 3. The divider is shared by both halves and starts from zero at reset. Source codes 5 to 7 hold the counter still.
- R2: Source code 4 counts rising edges of `evt_in`. The input passes through two synchronising flops, and each rising edge produces exactly one count, three clocks after the input rises.
- R3: When mode bit 0 is 0, both halves form one 16-bit counter. The high half advances when the low half wraps. The low configuration controls the whole counter, and the high configuration register has no effect.
- R4: When mode bit 0 is 1, each half counts with its own source, its own compare value, its own clear bit and its own flags (bits 0 and 1 for the low half, bits 2 and 3 for the high half).
- R5: A match flag is set on the edge where a tick moves a counter onto its compare value. In 16-bit mode the 16-bit value is compared, and the result goes to flag bit 3.
- R6: With clear on match enabled, the counter reads zero one clock after the match, whether or not a tick is due in that clock. That clear does not raise an overflow flag.
- R7: An overflow flag is set when a tick moves a counter from all ones to zero. In 16-bit mode this is flag bit 2.
- R8: Each 16-bit match inverts `cmp_pin`. In 8-bit mode only high half matches invert the pin.
- R9: A write to address 5 sets `cmp_pin` to the written bit 0 on that edge. After reset the pin is 0.
- R10: Flags stay set once raised. Writing a 0 to a flag bit clears it and writing a 1 leaves it unchanged. When an event and a clearing write fall in the same clock, the flag ends up set.
- R11: `irq` is high exactly when at least one flag bit and its enable bit are both 1.
- R12: A write to a counter address loads the written value. The write takes priority over a tick and over a pending clear, and no flag is raised in that clock.
- R13: Every register reads back its reset value after reset: configurations 0x07, compare values 0xFF, everything else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| evt_in | input | 1 | External event input, asynchronous |
| cmp_pin | output | 1 | Toggle output |
| irq | output | 1 | Interrupt request built from the enabled flags |

## Verification
The counter is driven from each divider tap in turn, and from the stopped codes, so that a wrong tap width or a wrong divider phase shows up as a count that drifts. The external input is driven with pulses of one clock and of several clocks to show the difference between edge counting and level counting, and between the expected latency and a wrong one. In 16-bit mode a low-half load near 0xFF exposes carry faults. Clear-on-match with the compare value at 0xFFFF separates a correct clear from a false overflow. In 8-bit mode the halves run at different rates with different compare values, which shows whether any state leaks between them and whether only the high half drives the pin.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef struct packed {
    logic       clr;
    logic [2:0] src;
  } slice_cfg_t;

  localparam int A_CFG_LO = 0;
  localparam int A_CFG_HI = 1;
  localparam int A_MODE   = 2;
  localparam int A_IEN    = 3;
  localparam int A_FLAGS  = 4;
  localparam int A_PIN    = 5;
  localparam int A_CNT_LO = 6;
  localparam int A_CNT_HI = 7;
  localparam int A_CMP_LO = 8;
  localparam int A_CMP_HI = 9;

  localparam int NTAPS    = 4;
  localparam int SRC_EXT  = 4;
  localparam logic [2:0] SRC_OFF = 3'd7;
endpackage

// File: rtl/sct_tick_gen.sv
module sct_tick_gen #(
  parameter int PW = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_in,
  output logic [sct_pkg::NTAPS:0] tick_vec
);
  localparam int TAPW [sct_pkg::NTAPS] = '{1, 2, 4, 5};

  logic [PW-1:0] presc_q;
  logic [2:0]    sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      sync_q  <= '0;
    end else begin
      presc_q <= presc_q + PW'(1);
      sync_q  <= {sync_q[1:0], evt_in};
    end
  end

  for (genvar g = 0; g < sct_pkg::NTAPS; g++) begin : g_tap
    assign tick_vec[g] = &presc_q[TAPW[g]-1:0];
  end

  assign tick_vec[sct_pkg::NTAPS] = sync_q[1] & ~sync_q[2];

  // R2: one count per rising edge, never two clocks in a row
  a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tick_vec[sct_pkg::NTAPS] |=> !tick_vec[sct_pkg::NTAPS]);
endmodule

// File: rtl/sct_slice.sv
module sct_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt_q,
  output logic         at_max
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wr)   cnt_q <= wr_val;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + W'(1);
  end

  assign at_max = &cnt_q;

  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt_q == $past(wr_val)));
endmodule

// File: rtl/split_cmp_timer.sv
module split_cmp_timer #(
  parameter int HW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [HW-1:0] bus_wdata,
  output logic [HW-1:0] bus_rdata,
  input  logic          evt_in,
  output logic          cmp_pin,
  output logic          irq
);
  import sct_pkg::*;

  localparam int FW = 2 * HW;

  slice_cfg_t    cfg_lo_q, cfg_hi_q;
  logic          split_q;
  logic [3:0]    ien_q, flags_q;
  logic          pin_q;
  logic [HW-1:0] cmp_lo_q, cmp_hi_q;
  logic          hit_lo_q, hit_hi_q;

  logic [NTAPS:0] tick_vec;
  logic [HW-1:0]  cnt_lo, cnt_hi;
  logic           lo_max, hi_max;

  function automatic logic pick(input logic [2:0] s, input logic [NTAPS:0] v);
    if (int'(s) <= NTAPS) return v[s];
    return 1'b0;
  endfunction

  logic wr_cfg_lo, wr_cfg_hi, wr_mode, wr_ien, wr_flags, wr_pin;
  logic wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi;
  assign wr_cfg_lo = bus_we && bus_addr == AW'(A_CFG_LO);
  assign wr_cfg_hi = bus_we && bus_addr == AW'(A_CFG_HI);
  assign wr_mode   = bus_we && bus_addr == AW'(A_MODE);
  assign wr_ien    = bus_we && bus_addr == AW'(A_IEN);
  assign wr_flags  = bus_we && bus_addr == AW'(A_FLAGS);
  assign wr_pin    = bus_we && bus_addr == AW'(A_PIN);
  assign wr_cnt_lo = bus_we && bus_addr == AW'(A_CNT_LO);
  assign wr_cnt_hi = bus_we && bus_addr == AW'(A_CNT_HI);
  assign wr_cmp_lo = bus_we && bus_addr == AW'(A_CMP_LO);
  assign wr_cmp_hi = bus_we && bus_addr == AW'(A_CMP_HI);

  sct_tick_gen #(.PW(5)) u_ticks (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .tick_vec(tick_vec)
  );

  // tick and clear routing depends on mode
  logic lo_tick, hi_tick, clr_lo_req, clr_hi_req;
  assign lo_tick    = pick(cfg_lo_q.src, tick_vec);
  assign hi_tick    = split_q ? pick(cfg_hi_q.src, tick_vec) : (lo_tick & lo_max);
  assign clr_lo_req = split_q ? (hit_lo_q & cfg_lo_q.clr) : (hit_hi_q & cfg_lo_q.clr);
  assign clr_hi_req = split_q ? (hit_hi_q & cfg_hi_q.clr) : (hit_hi_q & cfg_lo_q.clr);

  sct_slice #(.W(HW)) u_lo (
    .clk(clk), .rst_n(rst_n), .tick(lo_tick), .clr(clr_lo_req),
    .wr(wr_cnt_lo), .wr_val(bus_wdata), .cnt_q(cnt_lo), .at_max(lo_max)
  );

  sct_slice #(.W(HW)) u_hi (
    .clk(clk), .rst_n(rst_n), .tick(hi_tick), .clr(clr_hi_req),
    .wr(wr_cnt_hi), .wr_val(bus_wdata), .cnt_q(cnt_hi), .at_max(hi_max)
  );

  // compare and overflow events
  logic          lo_ok, hi_ok, full_ok;
  logic [HW-1:0] lo_next, hi_next;
  logic [FW-1:0] full_next;
  logic          m_lo, m_hi, m_16, o_lo, o_hi, o_16;
  logic [3:0]    set_vec;

  assign lo_ok     = lo_tick & ~wr_cnt_lo & ~clr_lo_req;
  assign hi_ok     = hi_tick & ~wr_cnt_hi & ~clr_hi_req;
  assign full_ok   = lo_tick & ~wr_cnt_lo & ~wr_cnt_hi & ~clr_lo_req;
  assign lo_next   = cnt_lo + HW'(1);
  assign hi_next   = cnt_hi + HW'(1);
  assign full_next = {cnt_hi, cnt_lo} + FW'(1);

  assign m_lo = split_q & lo_ok & (lo_next == cmp_lo_q);
  assign m_hi = split_q & hi_ok & (hi_next == cmp_hi_q);
  assign m_16 = ~split_q & full_ok & (full_next == {cmp_hi_q, cmp_lo_q});
  assign o_lo = split_q & lo_ok & lo_max;
  assign o_hi = split_q & hi_ok & hi_max;
  assign o_16 = ~split_q & full_ok & lo_max & hi_max;

  assign set_vec = {m_hi | m_16, o_hi | o_16, m_lo, o_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lo_q <= '{clr: 1'b0, src: SRC_OFF};
      cfg_hi_q <= '{clr: 1'b0, src: SRC_OFF};
      split_q  <= 1'b0;
      ien_q    <= '0;
      flags_q  <= '0;
      pin_q    <= 1'b0;
      cmp_lo_q <= '1;
      cmp_hi_q <= '1;
      hit_lo_q <= 1'b0;
      hit_hi_q <= 1'b0;
    end else begin
      if (wr_cfg_lo) cfg_lo_q <= slice_cfg_t'(bus_wdata[3:0]);
      if (wr_cfg_hi) cfg_hi_q <= slice_cfg_t'(bus_wdata[3:0]);
      if (wr_mode)   split_q  <= bus_wdata[0];
      if (wr_ien)    ien_q    <= bus_wdata[3:0];
      if (wr_cmp_lo) cmp_lo_q <= bus_wdata;
      if (wr_cmp_hi) cmp_hi_q <= bus_wdata;
      flags_q  <= (wr_flags ? (flags_q & bus_wdata[3:0]) : flags_q) | set_vec;
      if (wr_pin)                pin_q <= bus_wdata[0];
      else if (m_hi | m_16)      pin_q <= ~pin_q;
      hit_lo_q <= m_lo;
      hit_hi_q <= m_hi | m_16;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_CFG_LO): bus_rdata = HW'(cfg_lo_q);
      AW'(A_CFG_HI): bus_rdata = HW'(cfg_hi_q);
      AW'(A_MODE):   bus_rdata = HW'(split_q);
      AW'(A_IEN):    bus_rdata = HW'(ien_q);
      AW'(A_FLAGS):  bus_rdata = HW'(flags_q);
      AW'(A_PIN):    bus_rdata = HW'(pin_q);
      AW'(A_CNT_LO): bus_rdata = cnt_lo;
      AW'(A_CNT_HI): bus_rdata = cnt_hi;
      AW'(A_CMP_LO): bus_rdata = cmp_lo_q;
      AW'(A_CMP_HI): bus_rdata = cmp_hi_q;
      default:       bus_rdata = '0;
    endcase
  end

  assign cmp_pin = pin_q;
  assign irq     = |(flags_q & ien_q);

  // R6: a clear on match zeroes the low half on the next edge
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lo_req && !wr_cnt_lo) |=> (cnt_lo == '0));

  // R6: the clearing clock never raises the low overflow flag
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (split_q && clr_lo_req && !flags_q[0]) |=> !flags_q[0]);

  // R8: a match inverts the pin unless a preset write wins
  a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_hi || m_16) && !wr_pin) |=> (cmp_pin != $past(cmp_pin)));

  // R10: flags hold without a clearing write
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[2] && !wr_flags) |=> flags_q[2]);

  // R3: in 16-bit mode the high half moves only on a low-half wrap
  a_r3_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_q && !wr_cnt_hi && !clr_hi_req && !lo_max) |=> $stable(cnt_hi));
endmodule

// File: tb/split_cmp_timer_tb_top.sv
module split_cmp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       evt_in = 1'b0;
  logic       cmp_pin, irq;

  always #2 clk = ~clk;

  split_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .cmp_pin(cmp_pin), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R13";
  logic [3:0] watch = 4'd6;

  // behavioural reference state
  int m_src [2];
  int m_clr [2];
  int m_split, m_ien, m_flags, m_pin, m_p;
  int m_cnt [2];
  int m_cmp [2];
  int m_hit [2];
  int s1, s2, s3;

  function automatic int tick_of(int src);
    int divs [4] = '{2, 4, 16, 32};
    if (src < 4) return ((m_p % divs[src]) == divs[src] - 1) ? 1 : 0;
    if (src == 4) return (s2 == 1 && s3 == 0) ? 1 : 0;
    return 0;
  endfunction

  function automatic int model_read(int a);
    case (a)
      0: return m_clr[0] * 8 + m_src[0];
      1: return m_clr[1] * 8 + m_src[1];
      2: return m_split;
      3: return m_ien;
      4: return m_flags;
      5: return m_pin;
      6: return m_cnt[0];
      7: return m_cnt[1];
      8: return m_cmp[0];
      9: return m_cmp[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_src[i] = 7; m_clr[i] = 0; m_cnt[i] = 0; m_cmp[i] = 255; m_hit[i] = 0;
      end
      m_split = 0; m_ien = 0; m_flags = 0; m_pin = 0; m_p = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int a, wd, we, sets, tog;
      int nlo, nhi, nhit0, nhit1;
      a = int'(bus_addr); wd = int'(bus_wdata); we = int'(bus_we);
      sets = 0; tog = 0; nhit0 = 0; nhit1 = 0;
      nlo = m_cnt[0]; nhi = m_cnt[1];
      if (m_split == 1) begin
        for (int h = 0; h < 2; h++) begin
          int t, c, w, ok, nv, cur;
          t = tick_of(m_src[h]);
          c = m_hit[h] & m_clr[h];
          w = (we == 1 && a == 6 + h) ? 1 : 0;
          ok = (t == 1 && w == 0 && c == 0) ? 1 : 0;
          cur = m_cnt[h];
          nv = (cur + 1) % 256;
          if (ok == 1 && nv == m_cmp[h]) begin
            sets |= (2 << (2 * h));
            if (h == 0) nhit0 = 1; else begin nhit1 = 1; tog = 1; end
          end
          if (ok == 1 && cur == 255) sets |= (1 << (2 * h));
          if (w == 1) nv = wd; else if (c == 1) nv = 0; else if (t == 0) nv = cur;
          if (h == 0) nlo = nv; else nhi = nv;
        end
      end else begin
        int t, c, v, ok, nv;
        t = tick_of(m_src[0]);
        c = m_hit[1] & m_clr[0];
        v = m_cnt[1] * 256 + m_cnt[0];
        ok = (t == 1 && !(we == 1 && (a == 6 || a == 7)) && c == 0) ? 1 : 0;
        nv = (v + 1) % 65536;
        if (ok == 1 && nv == m_cmp[1] * 256 + m_cmp[0]) begin
          sets |= 8; nhit1 = 1; tog = 1;
        end
        if (ok == 1 && v == 65535) sets |= 4;
        if (we == 1 && a == 6) nlo = wd;
        else if (c == 1) nlo = 0;
        else if (t == 1) nlo = nv % 256;
        if (we == 1 && a == 7) nhi = wd;
        else if (c == 1) nhi = 0;
        else if (t == 1 && m_cnt[0] == 255) nhi = (m_cnt[1] + 1) % 256;
      end
      m_flags = ((we == 1 && a == 4) ? (m_flags & wd & 15) : m_flags) | sets;
      if (we == 1 && a == 5) m_pin = wd % 2;
      else if (tog == 1) m_pin = 1 - m_pin;
      if (we == 1) begin
        case (a)
          0: begin m_src[0] = wd % 8; m_clr[0] = (wd / 8) % 2; end
          1: begin m_src[1] = wd % 8; m_clr[1] = (wd / 8) % 2; end
          2: m_split = wd % 2;
          3: m_ien = wd % 16;
          8: m_cmp[0] = wd;
          9: m_cmp[1] = wd;
          default: ;
        endcase
      end
      m_cnt[0] = nlo; m_cnt[1] = nhi;
      m_hit[0] = nhit0; m_hit[1] = nhit1;
      m_p = (m_p + 1) % 32;
      s3 = s2; s2 = s1; s1 = int'(evt_in);
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare on every clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk($sformatf("rdata[%0d]", bus_addr), int'(bus_rdata), model_read(int'(bus_addr)));
      chk("cmp_pin (R8/R9)", int'(cmp_pin), m_pin);
      chk("irq (R11)", int'(irq), ((m_flags & m_ien) != 0) ? 1 : 0);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = watch;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(int a);
    watch = 4'(a);
    @(negedge clk);
    bus_addr = watch;
  endtask

  task automatic pulse(int hi, int lo);
    @(negedge clk); evt_in = 1'b1;
    repeat (hi) @(negedge clk);
    evt_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired in phase %s", tag);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R13: reset values of every register
    tag = "R13";
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); bus_addr = 4'(i);
    end
    @(negedge clk);
    chk("R9 pin after reset", int'(cmp_pin), 0);
    chk("R11 irq after reset", int'(irq), 0);

    // R1: each divider tap and the stopped codes
    tag = "R1"; look(6);
    wr(0, 0); idle(60);
    wr(0, 1); idle(60);
    wr(0, 2); idle(100);
    wr(0, 3); idle(200);
    wr(0, 6); idle(40);
    wr(0, 5); idle(20);

    // R2: external edges, short and long pulses
    tag = "R2";
    wr(0, 4);
    for (int i = 0; i < 6; i++) pulse(1, 2);
    for (int i = 0; i < 6; i++) pulse(4, 3);
    pulse(1, 1);
    idle(6);
    wr(0, 7);

    // R3: 16-bit carry, high configuration ignored
    tag = "R3";
    wr(6, 8'hF0); wr(7, 8'h12);
    wr(1, 8'h08);
    wr(0, 0); look(7); idle(120);
    look(6); idle(40);
    wr(1, 8'h0F); idle(40);
    wr(0, 7);

    // R6: 16-bit clear on match, pin toggles
    tag = "R6";
    wr(6, 0); wr(7, 0); wr(9, 0); wr(8, 8'h20); wr(3, 8'h0C);
    look(4); wr(0, 8'h08); idle(200);
    look(6); idle(80);
    wr(0, 7); wr(4, 0);

    // R7: 16-bit wrap raises overflow
    tag = "R7";
    wr(9, 0); wr(8, 8'h40); wr(7, 8'hFF); wr(6, 8'hF0);
    look(4); wr(0, 0); idle(80);
    wr(0, 7); wr(4, 0);

    // R6: compare at all ones with clear, no overflow
    tag = "R6";
    wr(9, 8'hFF); wr(8, 8'hFF); wr(7, 8'hFF); wr(6, 8'hF0);
    look(4); wr(0, 8'h08); idle(60);
    look(7); idle(20);
    wr(0, 7); wr(4, 0);

    // R5: match without clear keeps counting past compare
    tag = "R5";
    wr(7, 0); wr(6, 0); wr(9, 0); wr(8, 8'h10);
    look(4); wr(0, 1); idle(100);
    look(6); idle(30);
    wr(0, 7); wr(4, 0);

    // R4: two independent 8-bit timers
    tag = "R4";
    wr(2, 1); wr(6, 0); wr(7, 0);
    wr(8, 8'h10); wr(9, 8'h03);
    wr(3, 8'h0F);
    look(4); wr(0, 8'h08); wr(1, 8'h03); idle(400);
    look(6); idle(100);
    look(7); idle(300);
    wr(4, 0); look(5); idle(200);
    wr(1, 8'h0B); look(7); idle(300);
    wr(1, 7); wr(0, 0); wr(8, 8'h00); wr(6, 8'hF8); look(4); idle(60);
    wr(0, 7);

    // R9: preset writes force the pin
    tag = "R9";
    look(5);
    wr(5, 1); idle(3); wr(5, 0); idle(3); wr(5, 1); idle(3);

    // R10: write-zero-to-clear flags
    tag = "R10";
    look(4);
    wr(4, 8'h0F); idle(2);
    wr(4, 8'h0A); idle(2);
    wr(4, 8'h00); idle(2);
    wr(0, 8'h08); wr(8, 8'h04); wr(6, 0); idle(40);
    wr(4, 8'h05); idle(40);

    // R11: enables gate the interrupt
    tag = "R11";
    wr(3, 0); idle(10);
    wr(3, 8'h02); idle(10);
    wr(3, 8'h01); idle(10);
    wr(4, 0); idle(20);
    wr(0, 7);

    // R12: counter loads win over ticks and clears
    tag = "R12";
    look(6);
    wr(0, 8'h08); wr(8, 8'h80);
    wr(6, 8'h77); idle(30);
    wr(6, 8'h7E); idle(1); wr(6, 8'h7F); idle(1); wr(6, 8'h10); idle(20);
    wr(2, 0); wr(7, 8'h33); look(7); idle(20);
    wr(0, 7); idle(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule